// File: doc/BRIEF.md
# Comparator Edge Interrupt and Wake Flags

This block sits behind the conditioning logic of a pair of analog comparator channels. Each cycle it takes the conditioned level of every channel and looks for a transition of the kind that software selected for that channel. When a transition qualifies, the channel's sticky interrupt flag is set. If that channel also has both its wake enable and its interrupt enable set, a separate sticky wake flag is set. Software reads all flags in one status word and clears any subset by writing ones to a clear port.

A channel that is switched off contributes a constant low level and can raise no flag. When a channel is switched on, its first compared sample is taken one cycle after the enable, so the switch itself never looks like an edge. A single interrupt request line is high while any enabled channel has its interrupt flag set.

Top module: `cmp_evt_flags`

## Requirements
- R1: After reset, every bit of `status` and `irq` is 0.
- R2: With polarity code 2'b00 on a channel, a rising or a falling transition of its enabled level sets its interrupt flag (status bit equal to the channel index) on the clock edge after the new level is presented.
- R3: Polarity code 2'b01 reacts to rising transitions only, and code 2'b10 reacts to falling transitions only; the other direction leaves the flag at 0.
- R4: Polarity code 2'b11 never sets any flag of that channel, whatever the level does.
- R5: A channel whose enable is 0 sees a level of 0 and sets no flag. Turning the enable on, or off, while the level is high sets no flag; edges are compared from the second enabled cycle onwards.
- R6: A cycle with `clr_wr` high clears each status bit whose `clr_data` bit is 1; `clr_data` bits that are 0, and any `clr_data` while `clr_wr` is low, leave the flags unchanged. Interrupt flags are at bits 0 and 1, wake flags at bits 8 and 9.
- R7: When a qualifying edge and a clear of the same flag fall in one cycle, the flag ends up set.
- R8: `irq` is registered: one cycle after any channel has its interrupt flag (next value) set while its `irq_en` bit is 1, `irq` is 1; otherwise it is 0.
- R9: A qualifying edge sets the channel's wake flag (status bit 8 plus the channel index) only when both `wake_en` and `irq_en` of that channel are 1; the interrupt flag is set regardless of the enables.
- R10: Channels are independent: an edge on one channel changes no flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_level | input | NUM_CH | Conditioned comparator level per channel |
| ch_en | input | NUM_CH | Channel enable; 0 forces the level seen to 0 |
| irq_en | input | NUM_CH | Interrupt enable per channel |
| wake_en | input | NUM_CH | Wake-up enable per channel |
| edge_sel | input | 2*NUM_CH | Polarity code per channel: 00 any, 01 rising, 10 falling, 11 none |
| clr_wr | input | 1 | Clear strobe |
| clr_data | input | STAT_W | Write-1-to-clear mask aligned with `status` |
| status | output | STAT_W | Interrupt flags at bits 0.., wake flags at bits WAKE_BASE.. |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker watches on every cycle that a flag only rises on an enabled channel with a non-reserved polarity, that a rising-only channel raises its flag only when its level is high, that a flag only falls under a matching clear, that wake flags never rise without both enables and the interrupt flag, and that `irq` tracks the enabled flags one cycle late. Whether the right edge was detected at the right cycle, that falling-only and either-edge codes react to the proper direction, that enabling a channel at a high level creates no edge, and that set beats clear can only be shown by the bench's polarity and transition sweep and its directed scenarios.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [1:0] {
    POL_ANY  = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_NONE = 2'b11
  } pol_e;
endpackage

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       lvl,
  input  logic [1:0] pol,
  output logic       hit
);
  logic prev_q;
  logic en_q;
  logic lvl_g;
  logic armed;
  logic rise;
  logic fall;

  // Previous level is kept only while enabled; en_q delays comparison by
  // one cycle after enable so switching on is never seen as an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= lvl_g;
      en_q   <= en;
    end
  end

  always_comb begin
    lvl_g = en & lvl;
    armed = en & en_q;
    rise  = armed & lvl_g & ~prev_q;
    fall  = armed & ~lvl_g & prev_q;
    case (pol_e'(pol))
      POL_ANY:  hit = rise | fall;
      POL_RISE: hit = rise;
      POL_FALL: hit = fall;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_flag_bank.sv
module cmp_flag_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q;

  // Set has priority over clear so a simultaneous event is not lost.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr) | set;
  end

  assign flags = flags_q;
endmodule

// File: rtl/cmp_evt_flags.sv
module cmp_evt_flags #(
  parameter int NUM_CH    = 2,
  parameter int STAT_W    = 16,
  parameter int WAKE_BASE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   ch_level,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH-1:0]   irq_en,
  input  logic [NUM_CH-1:0]   wake_en,
  input  logic [2*NUM_CH-1:0] edge_sel,
  input  logic                clr_wr,
  input  logic [STAT_W-1:0]   clr_data,
  output logic [STAT_W-1:0]   status,
  output logic                irq
);
  localparam int SEL_W = 2;

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] wake_hit;
  logic [NUM_CH-1:0] int_clr;
  logic [NUM_CH-1:0] int_nxt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic              irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmp_edge_det u_det (
      .clk (clk),
      .rst (rst),
      .en  (ch_en[c]),
      .lvl (ch_level[c]),
      .pol (edge_sel[c*SEL_W +: SEL_W]),
      .hit (hit[c])
    );
  end

  always_comb begin
    wake_hit = hit & wake_en & irq_en;
    clr_vec  = clr_wr ? clr_data : '0;
    set_vec  = '0;
    set_vec[0 +: NUM_CH]         = hit;
    set_vec[WAKE_BASE +: NUM_CH] = wake_hit;
    int_clr  = clr_vec[0 +: NUM_CH];
    int_nxt  = (status[0 +: NUM_CH] & ~int_clr) | hit;
  end

  cmp_flag_bank #(.W(STAT_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set   (set_vec),
    .clr   (clr_vec),
    .flags (status)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(int_nxt & irq_en);
  end

  assign irq = irq_q;
endmodule

// File: rtl/cmp_evt_flags_chk.sv
module cmp_evt_flags_chk #(
  parameter int NUM_CH    = 2,
  parameter int STAT_W    = 16,
  parameter int WAKE_BASE = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   ch_level,
  input logic [NUM_CH-1:0]   ch_en,
  input logic [NUM_CH-1:0]   irq_en,
  input logic [NUM_CH-1:0]   wake_en,
  input logic [2*NUM_CH-1:0] edge_sel,
  input logic                clr_wr,
  input logic [STAT_W-1:0]   clr_data,
  input logic [STAT_W-1:0]   status,
  input logic                irq
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == |(status[NUM_CH-1:0] & $past(irq_en))); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $rose(status[c]) |-> $past(ch_en[c]) && $past(ch_en[c], 2)); // R5
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
      $rose(status[c]) |-> $past(edge_sel[2*c +: 2]) != 2'b11); // R4
    AST_RISE_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
      $rose(status[c]) && ($past(edge_sel[2*c +: 2]) == 2'b01) |-> $past(ch_level[c])); // R3
    AST_FLAG_FALL_CLR: assert property (@(posedge clk) disable iff (rst)
      $fell(status[c]) |-> $past(clr_wr && clr_data[c])); // R6
    AST_WAKE_FALL_CLR: assert property (@(posedge clk) disable iff (rst)
      $fell(status[WAKE_BASE+c]) |-> $past(clr_wr && clr_data[WAKE_BASE+c])); // R6
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $rose(status[WAKE_BASE+c]) |-> $past(wake_en[c] && irq_en[c]) && status[c]); // R9
  end
endmodule

bind cmp_evt_flags cmp_evt_flags_chk #(
  .NUM_CH(NUM_CH), .STAT_W(STAT_W), .WAKE_BASE(WAKE_BASE)
) u_chk (
  .clk(clk), .rst(rst), .ch_level(ch_level), .ch_en(ch_en),
  .irq_en(irq_en), .wake_en(wake_en), .edge_sel(edge_sel),
  .clr_wr(clr_wr), .clr_data(clr_data), .status(status), .irq(irq)
);

// File: tb/cmp_evt_flags_bench.sv
`timescale 1ns/1ps
module cmp_evt_flags_bench;
  localparam int N  = 2;
  localparam int SW = 16;
  localparam int WB = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  ch_level = '0;
  logic [N-1:0]  ch_en = '0;
  logic [N-1:0]  irq_en = '0;
  logic [N-1:0]  wake_en = '0;
  logic [2*N-1:0] edge_sel = '0;
  logic          clr_wr = 1'b0;
  logic [SW-1:0] clr_data = '0;
  logic [SW-1:0] status;
  logic          irq;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cmp_evt_flags u_cmp_evt_flags (
    .clk(clk), .rst(rst), .ch_level(ch_level), .ch_en(ch_en),
    .irq_en(irq_en), .wake_en(wake_en), .edge_sel(edge_sel),
    .clr_wr(clr_wr), .clr_data(clr_data), .status(status), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = '1;
    step();
    clr_wr = 1'b0; clr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    step();
    chk("R1 status after reset", 32'(status), 0);
    chk("R1 irq after reset", 32'(irq), 0);

    // Sweep: channel x polarity x direction, all interrupts enabled.
    ch_en = '1; irq_en = '1; wake_en = '0;
    for (int c = 0; c < N; c++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic from;
          logic exp;
          from = logic'(dir);
          edge_sel = '0;
          edge_sel[2*c +: 2] = 2'(sel);
          ch_level[c] = from;
          step(); step();
          clear_all();
          step();
          chk("R6 cleared before sweep point", 32'(status), 0);
          ch_level[c] = ~from;
          step();
          exp = (sel == 0) || (sel == 1 && !from) || (sel == 2 && from);
          if (sel == 0)      chk("R2 either edge", 32'(status), 32'(exp) << c);
          else if (sel == 3) chk("R4 reserved code", 32'(status), 32'(exp) << c);
          else               chk("R3 single polarity, R10 isolation", 32'(status), 32'(exp) << c);
          chk("R8 irq follows flag", 32'(irq), 32'(exp));
        end
      end
    end

    // Wake enable sweep on channel 0, either edge.
    edge_sel = '0; ch_level = '0;
    step(); step(); clear_all();
    for (int k = 0; k < 4; k++) begin
      irq_en  = {1'b1, k[0]};
      wake_en = {1'b0, k[1]};
      ch_level[0] = ~ch_level[0];
      step();
      chk("R9 wake flag gating", 32'(status), 32'(1) | (32'(k[0] & k[1]) << WB));
      chk("R8 irq uses enable", 32'(irq), 32'(k[0]));
      clear_all();
    end

    // Write-1-to-clear details.
    irq_en = '1; wake_en = '1;
    ch_level[0] = ~ch_level[0];
    step();
    chk("R9 both flags set", 32'(status), 32'h101);
    clr_wr = 1'b0; clr_data = '1; step();
    chk("R6 no strobe no clear", 32'(status), 32'h101);
    clr_wr = 1'b1; clr_data = 16'h0202; step();
    chk("R6 zero bits keep flags", 32'(status), 32'h101);
    clr_data = 16'h0100; step();
    chk("R6 clear wake bit only", 32'(status), 32'h001);
    clr_data = 16'h0001; step();
    clr_wr = 1'b0; clr_data = '0;
    chk("R6 clear interrupt bit", 32'(status), 0);
    chk("R8 irq drops after clear", 32'(irq), 0);

    // Set beats clear.
    ch_level[0] = ~ch_level[0]; step();
    chk("R7 flag set", 32'(status[0]), 1);
    ch_level[0] = ~ch_level[0];
    clr_wr = 1'b1; clr_data = 16'h0001;
    step();
    clr_wr = 1'b0; clr_data = '0;
    chk("R7 set wins over clear", 32'(status[0]), 1);
    clear_all();

    // Disabled channel and enable/disable at high level.
    wake_en = '0; ch_en[1] = 1'b0; ch_level[1] = 1'b0;
    step();
    for (int t = 0; t < 4; t++) begin
      ch_level[1] = ~ch_level[1];
      step();
    end
    chk("R5 disabled channel silent", 32'(status), 0);
    ch_level[1] = 1'b1; step();
    ch_en[1] = 1'b1; step(); step();
    chk("R5 enable at high level", 32'(status), 0);
    ch_level[1] = 1'b0; step();
    chk("R5 edge after enable", 32'(status), 32'h2);
    ch_level[1] = 1'b1; step();
    clear_all();
    ch_en[1] = 1'b0; step(); step();
    chk("R5 disable at high level", 32'(status), 0);
    chk("R8 irq idle", 32'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule